// File: doc/BRIEF.md
# Two-Bank Non-Power-of-Two Word Memory

This block is a single-port synchronous memory whose depth is not a power of two. In its target configuration it holds 40960 words of 36 bits behind a 16-bit address. A plain inferred array would round that depth up to 65536 words. Instead the storage is split into two power-of-two banks: a 32768-word lower bank and an 8192-word upper bank. The upper address bits pick the bank for each access, and only that bank is enabled. A read multiplexer then returns the word from the bank that was addressed.

Every enabled cycle performs a read. If it is also a write, the read returns the word as it was before the write. Read data appears one clock after the request. The bank choice and an out-of-range flag are registered together with the read, so the multiplexer always matches the word it passes on. Addresses from 40960 up to 65535 reach no bank: writes to them are dropped and reads from them return zero.

The geometry is set by three parameters: `AddrWidth`, `DataWidth` and `UpperAw`. The lower bank takes half of the address space. The upper bank holds 2^`UpperAw` words. The target configuration is 16, 36 and 13. The defaults are a smaller geometry of the same shape.

Top module: `bank_ram_top`

## Requirements
- R1: An address with its top bit clear (0 to 32767) reads and writes the lower bank, indexed by the low 15 address bits.
- R2: An address with bit 15 set and bits 14:13 both zero (32768 to 40959) reads and writes the upper bank, indexed by the low 13 address bits.
- R3: A write changes only the addressed word. A write to one bank leaves every word of the other bank unchanged, including the word at the same index.
- R4: Read data for a request made on one rising edge is on `rdData` right after the next rising edge and stays there until another enabled cycle.
- R5: A write to any address from 40960 to 65535 changes no stored word.
- R6: A read from any address from 40960 to 65535 returns all zeros on `rdData`.
- R7: A write cycle also reads. It returns the word held at that address before the write (read-first).
- R8: While `en` is low, nothing is written whatever `we`, `addr` and `wrData` carry, and `rdData` holds its value.
- R9: After reset and before the first enabled cycle, `rdData` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Synchronous active-low reset of the read path |
| en | input | 1 | Access request for this cycle |
| we | input | 1 | Write when high together with `en` |
| addr | input | AddrWidth (16) | Word address |
| wrData | input | DataWidth (36) | Word to write |
| rdData | output | DataWidth (36) | Word read one cycle after the request |

## Verification
The bench works on both sides of the bank seam: 32767 and 32768, plus the last valid word 40959. A decoder that tested the wrong bits would fold one bank onto the other there, and the bench would catch it as one word overwriting another. Writes to 40960 and 65535 alias onto lower index 8192 and 32767 and onto upper index 0 and 8191 if the range check is weak. The bench reads those words back after the stray writes, and it expects zeros from the stray reads. Read-first returns and idle cycles with `we` held high show up a mux that is not aligned to the read latency, a write that leaks through without `en`, and output that drifts while the block is idle.

// File: rtl/bank_ram_pkg.sv
package bank_ram_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic lowEn;
    logic lowWe;
    logic upEn;
    logic upWe;
    logic pickUpper;  // registered with the read
    logic zeroOut;    // registered with the read
  } bankCtrl_t;

endpackage

// File: rtl/bank_ram_bank.sv
module bank_ram_bank #(
  parameter int Aw = 9,
  parameter int Dw = 36
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          en,
  input  logic          we,
  input  logic [Aw-1:0] idx,
  input  logic [Dw-1:0] wrData,
  output logic [Dw-1:0] rdData
);
  localparam int Depth = 1 << Aw;

  logic [Dw-1:0] store [Depth];

  always_ff @(posedge clk) begin
    if (en && we) store[idx] <= wrData;
  end

  // Nonblocking read sees the old word: read-first.
  always_ff @(posedge clk) begin
    if (!rstN)   rdData <= '0;
    else if (en) rdData <= store[idx];
  end
endmodule

// File: rtl/bank_ram_ctrl.sv
module bank_ram_ctrl
  import bank_ram_pkg::*;
#(
  parameter int AddrWidth = 12,
  parameter int UpperAw   = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 en,
  input  logic                 we,
  input  logic [AddrWidth-1:0] addr,
  output bankCtrl_t            strobes
);
  localparam int GapBits = AddrWidth - 1 - UpperAw;

  logic hitLow, hitUp;
  logic pickUpperQ, zeroOutQ;

  always_comb begin
    hitLow = !addr[AddrWidth-1];
    hitUp  = addr[AddrWidth-1] && (addr[AddrWidth-2:UpperAw] == GapBits'(0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pickUpperQ <= 1'b0;
      zeroOutQ   <= 1'b1;
    end else if (en) begin
      pickUpperQ <= hitUp;
      zeroOutQ   <= !(hitLow || hitUp);
    end
  end

  always_comb begin
    strobes.lowEn     = en && hitLow;
    strobes.lowWe     = en && we && hitLow;
    strobes.upEn      = en && hitUp;
    strobes.upWe      = en && we && hitUp;
    strobes.pickUpper = pickUpperQ;
    strobes.zeroOut   = zeroOutQ;
  end
endmodule

// File: rtl/bank_ram_datapath.sv
module bank_ram_datapath
  import bank_ram_pkg::*;
#(
  parameter int AddrWidth = 12,
  parameter int DataWidth = 36,
  parameter int UpperAw   = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankCtrl_t            strobes,
  input  logic [AddrWidth-1:0] addr,
  input  logic [DataWidth-1:0] wrData,
  output logic [DataWidth-1:0] rdData
);
  localparam int LowerAw = AddrWidth - 1;

  logic [DataWidth-1:0] bankOut [2];

  for (genvar g = 0; g < 2; g++) begin : gBank
    localparam int BankAw = (g == 0) ? LowerAw : UpperAw;
    logic bankEn, bankWe;
    assign bankEn = (g == 0) ? strobes.lowEn : strobes.upEn;
    assign bankWe = (g == 0) ? strobes.lowWe : strobes.upWe;

    bank_ram_bank #(.Aw(BankAw), .Dw(DataWidth)) uBank (
      .clk    (clk),
      .rstN   (rstN),
      .en     (bankEn),
      .we     (bankWe),
      .idx    (addr[BankAw-1:0]),
      .wrData (wrData),
      .rdData (bankOut[g])
    );
  end

  always_comb begin
    if (strobes.zeroOut)        rdData = '0;
    else if (strobes.pickUpper) rdData = bankOut[1];
    else                        rdData = bankOut[0];
  end
endmodule

// File: rtl/bank_ram_top.sv
module bank_ram_top
  import bank_ram_pkg::*;
#(
  parameter int AddrWidth = 12,
  parameter int DataWidth = 36,
  parameter int UpperAw   = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 en,
  input  logic                 we,
  input  logic [AddrWidth-1:0] addr,
  input  logic [DataWidth-1:0] wrData,
  output logic [DataWidth-1:0] rdData
);
  bankCtrl_t ctrlStrobes;

  bank_ram_ctrl #(.AddrWidth(AddrWidth), .UpperAw(UpperAw)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .en      (en),
    .we      (we),
    .addr    (addr),
    .strobes (ctrlStrobes)
  );

  bank_ram_datapath #(.AddrWidth(AddrWidth), .DataWidth(DataWidth), .UpperAw(UpperAw)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (ctrlStrobes),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData)
  );
endmodule

// File: rtl/bank_ram_checker.sv
module bank_ram_checker
  import bank_ram_pkg::*;
#(
  parameter int AddrWidth = 12,
  parameter int DataWidth = 36,
  parameter int UpperAw   = 9
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 en,
  input logic                 we,
  input logic [AddrWidth-1:0] addr,
  input logic [DataWidth-1:0] wrData,
  input logic [DataWidth-1:0] rdData,
  input bankCtrl_t            strobes
);
  localparam int GapBits = AddrWidth - 1 - UpperAw;

  logic isLow, isUp, isOut;
  assign isLow = !addr[AddrWidth-1];
  assign isUp  = addr[AddrWidth-1] && (addr[AddrWidth-2:UpperAw] == GapBits'(0));
  assign isOut = !isLow && !isUp;

  AST_LOW_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    en && isLow |-> strobes.lowEn && !strobes.upEn);  // R1
  AST_UP_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    en && isUp |-> strobes.upEn && !strobes.lowEn);  // R2
  AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.lowWe, strobes.upWe}));  // R3
  AST_WRITE_BACK: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(rstN, 2) && en && !we && !isOut && $past(en && we) && addr == $past(addr)
    |=> rdData == $past(wrData, 2));  // R4
  AST_OOR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    en && isOut |-> !strobes.lowWe && !strobes.upWe);  // R5
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    en && isOut |=> rdData == '0);  // R6
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !en |-> !strobes.lowWe && !strobes.upWe);  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(rdData));  // R8
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> rdData == '0);  // R9
endmodule

bind bank_ram_top bank_ram_checker #(
  .AddrWidth(AddrWidth), .DataWidth(DataWidth), .UpperAw(UpperAw)
) uChecker (
  .clk     (clk),
  .rstN    (rstN),
  .en      (en),
  .we      (we),
  .addr    (addr),
  .wrData  (wrData),
  .rdData  (rdData),
  .strobes (ctrlStrobes)
);

// File: tb/tb_bank_ram_top.sv
module tb_bank_ram_top;
  localparam int Aw    = 16;
  localparam int Dw    = 36;
  localparam int UpAw  = 13;
  localparam int Words = (1 << (Aw - 1)) + (1 << UpAw);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          en = 1'b0;
  logic          we = 1'b0;
  logic [Aw-1:0] addr = '0;
  logic [Dw-1:0] wrData = '0;
  logic [Dw-1:0] rdData;

  logic [Dw-1:0] refMem [Words];
  bit            known  [Words];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bank_ram_top #(.AddrWidth(Aw), .DataWidth(Dw), .UpperAw(UpAw)) dut (
    .clk(clk), .rstN(rstN), .en(en), .we(we),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [Dw-1:0] got, input logic [Dw-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [Dw-1:0] pat(input int a, input int salt);
    return {4'(salt), 16'(a), 16'(a * 7 + salt)};
  endfunction

  // One access; returns rdData sampled after the following edge.
  task automatic access(input int a, input bit w, input logic [Dw-1:0] d, output logic [Dw-1:0] got);
    @(negedge clk);
    en = 1'b1; we = w; addr = Aw'(a); wrData = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
    got = rdData;
  endtask

  task automatic writeWord(input int a, input logic [Dw-1:0] d, input string tag);
    logic [Dw-1:0] got;
    bit inRange = (a < Words);
    bit hadOld  = inRange && known[a];
    logic [Dw-1:0] old = hadOld ? refMem[a] : '0;
    access(a, 1'b1, d, got);
    if (!inRange) check({tag, " R6 write-oor read zero"}, got, '0);
    else if (hadOld) check({tag, " R7 read-first old"}, got, old);
    if (inRange) begin refMem[a] = d; known[a] = 1'b1; end
  endtask

  task automatic readWord(input int a, input string tag);
    logic [Dw-1:0] got;
    access(a, 1'b0, '0, got);
    if (a >= Words) check({tag, " R6 oor read"}, got, '0);
    else if (known[a]) check($sformatf("%s addr %0d", tag, a), got, refMem[a]);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R9 reset output", rdData, '0);
  endtask

  task automatic testLowerBank();
    int addrs[5] = '{0, 1, 12345, 8192, 32767};
    foreach (addrs[i]) writeWord(addrs[i], pat(addrs[i], 1), "R1");
    foreach (addrs[i]) readWord(addrs[i], "R1 lower R4");
  endtask

  task automatic testUpperBank();
    int addrs[5] = '{32768, 32769, 36000, 40000, 40959};
    foreach (addrs[i]) writeWord(addrs[i], pat(addrs[i], 2), "R2");
    foreach (addrs[i]) readWord(addrs[i], "R2 upper R4");
  endtask

  task automatic testIsolation();
    writeWord(0, 36'hAAAA_5555_1, "R3");
    writeWord(32768, 36'h1234_5678_9, "R3");
    writeWord(8191, 36'hF0F0_F0F0_F, "R3");
    writeWord(40959, 36'h0F0F_0F0F_0, "R3");
    readWord(0, "R3 isolation");
    readWord(32768, "R3 isolation");
    readWord(8191, "R3 isolation");
    readWord(40959, "R3 isolation");
    readWord(32767, "R3 seam");
  endtask

  task automatic testOutOfRange();
    int bad[4] = '{40960, 49152, 57343, 65535};
    foreach (bad[i]) writeWord(bad[i], {Dw{1'b1}}, "R5");
    foreach (bad[i]) readWord(bad[i], "R6");
    readWord(8192, "R5 alias lower");
    readWord(32767, "R5 alias lower");
    readWord(32768, "R5 alias upper");
    readWord(40959, "R5 alias upper");
    // Valid read then oor read: mux must switch to zero.
    readWord(40959, "R6 before");
    readWord(40960, "R6 after valid");
  endtask

  task automatic testReadFirst();
    writeWord(12345, 36'h9_8765_4321, "R7 lower");
    readWord(12345, "R7 new value");
    writeWord(40000, 36'h1_1111_2222, "R7 upper");
    readWord(40000, "R7 new value");
  endtask

  task automatic testIdle();
    logic [Dw-1:0] held;
    readWord(32768, "R8 setup");
    held = rdData;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      en = 1'b0; we = 1'b1; addr = Aw'(i == 0 ? 1 : 36000); wrData = {Dw{1'b1}};
      @(negedge clk);
      check("R8 idle hold", rdData, held);
    end
    we = 1'b0;
    readWord(1, "R8 no write");
    readWord(36000, "R8 no write");
  endtask

  task automatic testSweep();
    for (int a = 0; a < Words; a += 7) writeWord(a, pat(a, 3), "R3 sweep");
    for (int a = 0; a < Words; a += 7) readWord(a, "R3 sweep R1 R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLowerBank();
    testUpperBank();
    testIsolation();
    testOutOfRange();
    testReadFirst();
    testIdle();
    testSweep();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired got running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule